// File: doc/BRIEF.md
# Staircase-Ramp Comparator Error Digitizer

This block turns a one-bit comparator into the error sensor of a switching converter's voltage loop, so that no ADC is needed. Each switching period starts with a strobe. A counter then steps once per clock through every position of a staircase, and a lookup turns each position into a reference code for an external DAC. The DAC output sweeps across a window centred a little above the set point. An external comparator reports when that moving reference rises past the sensed output voltage. The counter position at the first synchronized rising edge of the comparator becomes the error sample for the period.

The DAC and the comparator together delay the crossing by a few clocks. A shift register moves the table address ahead of the counter by a fixed number of steps, so the reference on the wire matches the position that is captured. The shifted address is clamped to the top of the table. When no crossing happens in a sweep, the sample saturates to the low end or the high end, chosen by the comparator level at the end of the sweep. Every finished sweep produces exactly one single-cycle valid pulse, which a downstream control law can use to start its computation.

Top module: `ramp_err_digitizer`

## Requirements
- R1: After reset, dac_code is 0, sample_valid is 0, err_sample is 0 and sweep_active is 0. The shift register holds SHIFT_INIT, which is 4 by default.
- R2: A period_start pulse sets the count to 0 and raises sweep_active on the next clock. The count then rises by one per clock up to 2^ADDR_W-1, after which sweep_active falls. One clock after that, dac_code returns to the idle code, which is table entry 0.
- R3: During a sweep, dac_code is the table entry at address count+shift, and it appears one clock after the count. With the default parameters the rising table is the identity: code = address.
- R4: A clock with shift_load high copies shift_in into the shift register. The new value applies to all later addresses.
- R5: When count+shift exceeds 2^ADDR_W-1, the address is clamped to 2^ADDR_W-1, so dac_code stays at the top code (255 by default).
- R6: comp_in passes through a SYNC_STAGES-flop synchronizer (2 by default). If comp_in rises from low to high during the clock in which the count is j, err_sample becomes j+2, and sample_valid is high in the clock that follows the capture.
- R7: Only the first rising crossing in a sweep is captured. Later falls and rises of comp_in in the same sweep leave err_sample unchanged and produce no further valid pulse.
- R8: If no synchronized rising edge is seen by the last count and the synchronized comparator is low at that point, err_sample saturates to 2^ADDR_W-1 (255).
- R9: If no rising edge is seen and the synchronized comparator is high at the last count (it was already high when the sweep began), err_sample saturates to 0.
- R10: sample_valid lasts exactly one clock, once per completed sweep. err_sample holds its value until the next valid pulse.
- R11: A period_start during a sweep restarts the count from 0 and discards any capture that has not yet completed. Only the restarted sweep reports a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | Start of switching period; restarts the sweep |
| comp_in | input | 1 | Asynchronous comparator output, high when the reference is above the sensed voltage |
| shift_load | input | 1 | Writes shift_in into the delay-shift register |
| shift_in | input | SHIFT_W | New forward address shift |
| dac_code | output | CODE_W | Reference code for the external DAC |
| sweep_active | output | 1 | High while the staircase is being walked |
| err_sample | output | ADDR_W | Captured crossing position for the last period |
| sample_valid | output | 1 | One-clock pulse when err_sample is updated |

## Verification
The bench builds the block with its defaults: an 8-bit address and code, a rising identity table, two synchronizer stages, and a 4-bit shift that starts at 4. With these values a full 256-step sweep fits easily within the run. They also allow loading the largest shift, 15, so the clamp takes effect over the last fifteen steps. The two-stage synchronizer fixes the capture offset at two counts. That offset puts a comparator rise two steps before the end exactly on the boundary between a real capture and a high-end saturation.

// File: rtl/rampdig_pkg.sv
package rampdig_pkg;

   // Staircase value for one address: scales an address range onto a code range
   function automatic int unsigned stair_code(input int unsigned addr,
                                              input int unsigned addr_max,
                                              input int unsigned code_max);
      return (addr * code_max + addr_max / 2) / addr_max;
   endfunction

endpackage

// File: rtl/rampdig_sync.sv
module rampdig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rampdig_sweep.sv
module rampdig_sweep #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned SHIFT_W    = 4,
   parameter int unsigned SHIFT_INIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               shift_load,
   input  logic [SHIFT_W-1:0] shift_in,
   output logic [ADDR_W-1:0]  count,
   output logic               active,
   output logic               last,
   output logic [ADDR_W-1:0]  addr
);
   localparam int unsigned AMAX  = (1 << ADDR_W) - 1;
   localparam int unsigned SUM_W = ADDR_W + 1;

   logic [SHIFT_W-1:0] shift_q;
   logic [SUM_W-1:0]   sum;

   always_ff @(posedge clk) begin
      if (!rst_n)          shift_q <= SHIFT_W'(SHIFT_INIT);
      else if (shift_load) shift_q <= shift_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         active <= 1'b0;
      end else if (start) begin
         count  <= '0;
         active <= 1'b1;
      end else if (active) begin
         if (count == ADDR_W'(AMAX)) active <= 1'b0;
         else                        count  <= count + 1'b1;
      end
   end

   assign last = active && (count == ADDR_W'(AMAX));
   assign sum  = SUM_W'(count) + SUM_W'(shift_q);

   always_comb begin
      if (!active)                 addr = '0;
      else if (sum > SUM_W'(AMAX)) addr = ADDR_W'(AMAX);
      else                         addr = sum[ADDR_W-1:0];
   end

   // R2: one step per clock while sweeping
   a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start && count != ADDR_W'(AMAX)) |=> count == ADDR_W'($past(count) + 1'b1));
   // R2: sweep ends after the last position
   a_r2_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !active);
   // R11: a start always restarts from position zero
   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active && count == '0));
endmodule

// File: rtl/rampdig_table.sv
module rampdig_table #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CODE_W  = 8,
   parameter bit          FALLING = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [CODE_W-1:0] code
);
   import rampdig_pkg::*;

   localparam int unsigned AMAX = (1 << ADDR_W) - 1;
   localparam int unsigned CMAX = (1 << CODE_W) - 1;
   localparam logic [CODE_W-1:0] IDLE_CODE = FALLING ? CODE_W'(CMAX) : '0;

   logic [CODE_W-1:0] code_c;

   generate
      if (FALLING) begin : g_falling
         always_comb code_c = CODE_W'(CMAX - stair_code(32'(addr), AMAX, CMAX));
      end else begin : g_rising
         always_comb code_c = CODE_W'(stair_code(32'(addr), AMAX, CMAX));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) code <= IDLE_CODE;
      else        code <= code_c;
   end
endmodule

// File: rtl/rampdig_capture.sv
module rampdig_capture #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              last,
   input  logic [ADDR_W-1:0] count,
   input  logic              comp_s,
   output logic [ADDR_W-1:0] err,
   output logic              valid
);
   localparam int unsigned AMAX = (1 << ADDR_W) - 1;

   logic comp_d;
   logic taken;
   logic rise;

   assign rise = comp_s && !comp_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         comp_d <= 1'b0;
         taken  <= 1'b0;
         err    <= '0;
         valid  <= 1'b0;
      end else begin
         comp_d <= comp_s;
         valid  <= 1'b0;
         if (start) begin
            taken <= 1'b0;
         end else if (active && !taken) begin
            if (rise) begin
               err   <= count;
               valid <= 1'b1;
               taken <= 1'b1;
            end else if (last) begin
               err   <= comp_s ? '0 : ADDR_W'(AMAX);
               valid <= 1'b1;
               taken <= 1'b1;
            end
         end
      end
   end

   // R10: valid is a single-clock pulse
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R10: sample holds between pulses
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(err));
   // R6: a sample only comes out of an active sweep
   a_r6_from_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(active));
endmodule

// File: rtl/ramp_err_digitizer.sv
module ramp_err_digitizer #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CODE_W       = 8,
   parameter int unsigned SHIFT_W      = 4,
   parameter int unsigned SHIFT_INIT   = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          RAMP_FALLING = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               period_start,
   input  logic               comp_in,
   input  logic               shift_load,
   input  logic [SHIFT_W-1:0] shift_in,
   output logic [CODE_W-1:0]  dac_code,
   output logic               sweep_active,
   output logic [ADDR_W-1:0]  err_sample,
   output logic               sample_valid
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (SHIFT_W <= ADDR_W) else $error("SHIFT_W must not exceed ADDR_W");
      assert (SHIFT_INIT < (1 << SHIFT_W)) else $error("SHIFT_INIT does not fit SHIFT_W");
      assert (ADDR_W >= 2 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (CODE_W >= 2 && CODE_W <= 16) else $error("CODE_W out of range");
   end

   logic              comp_s;
   logic [ADDR_W-1:0] count;
   logic              last;
   logic [ADDR_W-1:0] addr;

   rampdig_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (comp_in),
      .q_sync  (comp_s)
   );

   rampdig_sweep #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .SHIFT_INIT(SHIFT_INIT)) i_sweep (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (period_start),
      .shift_load (shift_load),
      .shift_in   (shift_in),
      .count      (count),
      .active     (sweep_active),
      .last       (last),
      .addr       (addr)
   );

   rampdig_table #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .FALLING(RAMP_FALLING)) i_table (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .code  (dac_code)
   );

   rampdig_capture #(.ADDR_W(ADDR_W)) i_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (period_start),
      .active (sweep_active),
      .last   (last),
      .count  (count),
      .comp_s (comp_s),
      .err    (err_sample),
      .valid  (sample_valid)
   );

   // R2: the reference stays parked while no sweep runs
   a_r2_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (!sweep_active && !$past(sweep_active)) |=> $stable(dac_code));
endmodule

// File: tb/test_ramp_err_digitizer.sv
module test_ramp_err_digitizer;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       period_start = 1'b0;
   logic       comp_in = 1'b0;
   logic       shift_load = 1'b0;
   logic [3:0] shift_in = '0;
   logic [7:0] dac_code;
   logic       sweep_active;
   logic [7:0] err_sample;
   logic       sample_valid;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ramp_err_digitizer i_ramp_err_digitizer (
      .clk          (clk),
      .rst_n        (rst_n),
      .period_start (period_start),
      .comp_in      (comp_in),
      .shift_load   (shift_load),
      .shift_in     (shift_in),
      .dac_code     (dac_code),
      .sweep_active (sweep_active),
      .err_sample   (err_sample),
      .sample_valid (sample_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_shift(input int val);
      @(negedge clk);
      shift_in   = 4'(val);
      shift_load = 1'b1;
      @(negedge clk);
      shift_load = 1'b0;
   endtask

   // Runs one sweep. Loop index j is the count of the current clock.
   // Toggles comp_in at up1/dn1/up2, restarts at ab; -1 disables an event.
   task automatic run_sweep(input int up1, input int dn1, input int up2, input int ab,
                            input int shift, input int len,
                            output int npulse, output int err_v, output int valid_j,
                            output int dac_bad, output int first_bad_j);
      npulse = 0; err_v = -1; valid_j = -1; dac_bad = 0; first_bad_j = -1;
      @(negedge clk);
      period_start = 1'b1;
      @(negedge clk);
      period_start = 1'b0;
      for (int j = 0; j < len; j++) begin
         if (sample_valid) begin
            npulse++;
            err_v   = err_sample;
            valid_j = j;
         end
         if (ab < 0 && j >= 1 && j <= 256) begin
            int e = (j - 1 + shift > 255) ? 255 : j - 1 + shift;
            if (dac_code != 8'(e)) begin
               dac_bad++;
               if (first_bad_j < 0) first_bad_j = j;
            end
         end
         if (j == up1) comp_in = 1'b1;
         if (j == dn1) comp_in = 1'b0;
         if (j == up2) comp_in = 1'b1;
         if (j == ab)  period_start = 1'b1;
         if (j == ab + 1) period_start = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(dac_code == 8'd0, "R1 dac_code after reset", dac_code, 0);
      check(sample_valid == 1'b0, "R1 sample_valid after reset", sample_valid, 0);
      check(err_sample == 8'd0, "R1 err_sample after reset", err_sample, 0);
      check(sweep_active == 1'b0, "R1 sweep_active after reset", sweep_active, 0);
   endtask

   task automatic t_ramp_default();
      int np, ev, vj, bad, fb;
      comp_in = 1'b0;
      run_sweep(-1, -1, -1, -1, 4, 260, np, ev, vj, bad, fb);
      check(bad == 0, "R3 R1 staircase with reset shift 4, first bad step", fb, -1);
      check(np == 1 && vj == 256, "R8 one saturated pulse at sweep end, index", vj, 256);
      check(ev == 255, "R8 no crossing with comparator low saturates high", ev, 255);
      check(sweep_active == 1'b0, "R2 sweep_active low after sweep", sweep_active, 0);
      check(dac_code == 8'd0, "R2 dac_code parked at idle code", dac_code, 0);
   endtask

   task automatic t_shift_clamp();
      int np, ev, vj, bad, fb;
      load_shift(15);
      comp_in = 1'b0;
      run_sweep(-1, -1, -1, -1, 15, 260, np, ev, vj, bad, fb);
      check(bad == 0, "R4 R5 staircase with shift 15 and clamp, first bad step", fb, -1);
      load_shift(0);
      run_sweep(-1, -1, -1, -1, 0, 260, np, ev, vj, bad, fb);
      check(bad == 0, "R4 staircase with shift 0, first bad step", fb, -1);
   endtask

   task automatic t_crossing(input int j0);
      int np, ev, vj, bad, fb;
      comp_in = 1'b0;
      run_sweep(j0, j0 + 30, -1, -1, 0, 300, np, ev, vj, bad, fb);
      check(ev == j0 + 2, "R6 captured crossing position", ev, j0 + 2);
      check(np == 1, "R10 exactly one valid pulse", np, 1);
      repeat (3) @(negedge clk);
      check(err_sample == 8'(j0 + 2), "R10 sample held after pulse", err_sample, j0 + 2);
      comp_in = 1'b0;
   endtask

   task automatic t_first_only();
      int np, ev, vj, bad, fb;
      comp_in = 1'b0;
      run_sweep(10, 20, 30, -1, 0, 300, np, ev, vj, bad, fb);
      check(ev == 12, "R7 only first rising crossing captured", ev, 12);
      check(np == 1, "R7 later crossing gives no pulse", np, 1);
      comp_in = 1'b0;
   endtask

   task automatic t_late_edge();
      int np, ev, vj, bad, fb;
      comp_in = 1'b0;
      run_sweep(252, -1, -1, -1, 0, 300, np, ev, vj, bad, fb);
      check(ev == 254, "R6 crossing near end still captured", ev, 254);
      comp_in = 1'b0;
      repeat (4) @(negedge clk);
      run_sweep(254, -1, -1, -1, 0, 300, np, ev, vj, bad, fb);
      check(ev == 255 && np == 1, "R8 crossing too late to sync saturates high", ev, 255);
      comp_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_sat_high();
      int np, ev, vj, bad, fb;
      comp_in = 1'b1;
      repeat (6) @(negedge clk);
      run_sweep(-1, -1, -1, -1, 0, 300, np, ev, vj, bad, fb);
      check(ev == 0, "R9 comparator high all sweep saturates low", ev, 0);
      check(np == 1, "R9 one pulse for saturated sweep", np, 1);
      comp_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_abort();
      int np, ev, vj, bad, fb;
      comp_in = 1'b0;
      // restart at count 100; new sweep count 0 falls on loop index 101
      run_sweep(151, -1, -1, 100, 0, 420, np, ev, vj, bad, fb);
      check(ev == 52, "R11 restarted sweep captures its own crossing", ev, 52);
      check(np == 1, "R11 aborted sweep gives no pulse", np, 1);
      comp_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ramp_default();
      t_shift_clamp();
      t_crossing(40);
      t_crossing(0);
      t_first_only();
      t_late_edge();
      t_sat_high();
      t_abort();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule